// File: doc/BRIEF.md
# Port-Tagged Transmit FIFO with Packet-Framing Repair

This block is one shared transmit buffer. Each word written into it carries a data payload, an 8-bit destination port tag and start-of-packet and end-of-packet markers. Words leave the buffer in exactly the order they were written. The block does no scheduling and no reordering, so the user logic decides the order of bursts on the link by the order in which it writes. The write side and the read side have separate clocks. The depth is 2^ADDR_W words. The two sides exchange Gray-coded pointers through two-flop synchronizers, which makes the full and empty flags conservative.

Before a word is stored, a framing checker in the write domain looks it up by its tag. The checker keeps one "inside a packet" bit for each port below `NUM_PORTS`, and it repairs broken SOP/EOP framing:

- It forces SOP on a word that opens a packet without one.
- It reports each repair on sticky flags and on a one-cycle pulse.

Words for ports at or above `NUM_PORTS` are stored unchecked. The full 8-bit tag always passes through unchanged. A write into a full buffer is dropped and reported as an overflow when `DROP_ON_FULL` is 1.

Top module: `tagged_tx_fifo`

## Requirements
- R1: Words are read out in write order, with data, all 8 tag bits, SOP and EOP unchanged unless a framing repair applies.
- R2: A word for a checked port that is outside a packet, with SOP=0 and EOP=0, is stored with SOP=1. It sets err_flags bit 0 (missing SOP) and pulses err_pulse.
- R3: A word for a checked port that is outside a packet, with SOP=0 and EOP=1, is stored with SOP=1 and EOP=1. It sets err_flags bit 3 (spurious EOP) and pulses err_pulse.
- R4: A word with SOP=1 for a checked port that is already inside a packet is stored unchanged. It sets err_flags bit 1 (spurious SOP) and bit 2 (missing EOP).
- R5: Words whose tag is NUM_PORTS or higher are stored unmodified and never raise a framing flag.
- R6: A well-formed packet raises no flag. An accepted EOP returns the port to the outside-packet state, so the next SOP on that port is legal.
- R7: After reset rd_empty=1, wr_full=0 and all flags are 0. rd_empty falls on the second read-clock edge after the write edge, and a read from an empty buffer has no effect.
- R8: With DROP_ON_FULL=1, a write while wr_full=1 is discarded, sets the sticky ovf_flag and leaves the stored words intact.
- R9: err_clr clears err_flags and ovf_flag at the next write-clock edge. A flag raised in that same cycle still sets.
- R10: wr_full rises in the cycle after the 2^ADDR_W-th write when nothing has been read.

Framing errors are reported on `err_flags` with this bit layout:

| Bit | Meaning |
|-----|---------|
| 0 | missing SOP |
| 1 | spurious SOP |
| 2 | missing EOP |
| 3 | spurious EOP |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Payload of the written word |
| wr_tag | input | 8 | Destination port tag |
| wr_sop | input | 1 | Start-of-packet marker |
| wr_eop | input | 1 | End-of-packet marker |
| err_clr | input | 1 | Synchronous clear of the sticky flags |
| wr_full | output | 1 | Buffer full (write domain) |
| err_flags | output | 4 | Sticky framing flags (see the bit table above) |
| err_pulse | output | 1 | One-cycle pulse after a repaired word is stored |
| ovf_flag | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous active-high reset |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | DATA_W | Head word payload (shown ahead) |
| rd_tag | output | 8 | Head word tag |
| rd_sop | output | 1 | Head word SOP |
| rd_eop | output | 1 | Head word EOP |
| rd_empty | output | 1 | Buffer empty (read domain) |

## Verification
- **Write-side results:** err_pulse, err_flags, ovf_flag and wr_full are registered on the write edge that takes the word. The bench drives on falling edges and samples at the falling edge that follows the write edge.
- **Head word:** it is shown ahead, so its fields are compared before the pop.
- **Empty flag:** rd_empty falls only after the two synchronizer stages. The bench checks it still high one and a half cycles after the write edge and low one cycle later.
- **Overflow:** it is checked by reading back all 2^ADDR_W words after a dropped write.

// File: rtl/tagfifo_pkg.sv
`timescale 1ns/1ps
package tagfifo_pkg;
    localparam int PORT_W  = 8;
    localparam int N_FLAGS = 4;
    localparam int FLG_MISS_SOP = 0;
    localparam int FLG_SPUR_SOP = 1;
    localparam int FLG_MISS_EOP = 2;
    localparam int FLG_SPUR_EOP = 3;

    typedef struct packed {
        logic [PORT_W-1:0] tag;
        logic              sop;
        logic              eop;
    } frame_t;

    localparam int FRAME_W = PORT_W + 2;

    function automatic logic is_checked(input logic [PORT_W-1:0] tag, input int nports);
        return ({1'b0, tag} < (PORT_W+1)'(nports));
    endfunction
endpackage

// File: rtl/tf_sync2.sv
`timescale 1ns/1ps
module tf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/tf_framer.sv
`timescale 1ns/1ps
module tf_framer
    import tagfifo_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               accept,
    input  frame_t             in_frm,
    output frame_t             out_frm,
    output logic [N_FLAGS-1:0] err_flags,
    output logic               err_pulse
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [NUM_PORTS-1:0] in_pkt;
    logic                 checked;
    logic [IDX_W-1:0]     idx;
    logic                 cur;
    logic [N_FLAGS-1:0]   det;
    logic [N_FLAGS-1:0]   evt;

    always_comb begin
        checked = is_checked(in_frm.tag, NUM_PORTS);
        idx     = in_frm.tag[IDX_W-1:0];
        cur     = checked ? in_pkt[idx] : 1'b0;

        det = '0;
        det[FLG_MISS_SOP] = checked && !cur && !in_frm.sop && !in_frm.eop;
        det[FLG_SPUR_EOP] = checked && !cur && !in_frm.sop &&  in_frm.eop;
        det[FLG_SPUR_SOP] = checked &&  cur &&  in_frm.sop;
        det[FLG_MISS_EOP] = checked &&  cur &&  in_frm.sop;
        evt = det & {N_FLAGS{accept}};

        out_frm     = in_frm;
        out_frm.sop = in_frm.sop | (checked && !cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt <= '0;
        end else if (accept && checked) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (idx == IDX_W'(p)) in_pkt[p] <= !out_frm.eop;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flags <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_flags <= (clr ? '0 : err_flags) | evt;
            err_pulse <= |evt;
        end
    end

    assert_pulse_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_flags != '0));

    assert_clear_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && (evt == '0)) |=> (err_flags == '0));

    assert_eop_closes_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && checked && out_frm.eop) |=> !in_pkt[$past(idx)]);
endmodule

// File: rtl/tf_dcfifo.sv
`timescale 1ns/1ps
module tf_dcfifo #(
    parameter int W            = 26,
    parameter int ADDR_W       = 3,
    parameter bit DROP_ON_FULL = 1'b1
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         wr_req,
    input  logic [W-1:0] wdata,
    output logic         full,
    output logic         accept,
    output logic         ovf_evt,
    input  logic         rclk,
    input  logic         rrst,
    input  logic         rd_en,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r;
    logic [PW-1:0] wbin_nx, rbin_nx;
    logic          pop;

    tf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w));
    tf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r));

    // write domain
    assign full    = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    assign ovf_evt = wr_req && full;

    generate
        if (DROP_ON_FULL) begin : g_drop
            assign accept = wr_req && !full;
            assert_no_push_full_R8: assert property (@(posedge wclk) disable iff (wrst)
                (wr_req && full) |=> $stable(wbin));
        end else begin : g_keep
            assign accept = wr_req;
        end
    endgenerate

    assign wbin_nx = wbin + PW'(1);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (accept) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (accept) mem[wbin[ADDR_W-1:0]] <= wdata;
    end

    // read domain
    assign empty   = (rgray == wgray_r);
    assign pop     = rd_en && !empty;
    assign rbin_nx = rbin + PW'(1);
    assign rdata   = mem[rbin[ADDR_W-1:0]];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    assert_no_pop_empty_R7: assert property (@(posedge rclk) disable iff (rrst)
        (rd_en && empty) |=> $stable(rbin));
endmodule

// File: rtl/tagged_tx_fifo.sv
`timescale 1ns/1ps
module tagged_tx_fifo
    import tagfifo_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 3,
    parameter int NUM_PORTS    = 4,
    parameter bit DROP_ON_FULL = 1'b1
) (
    input  logic               wr_clk,
    input  logic               wr_rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [PORT_W-1:0]  wr_tag,
    input  logic               wr_sop,
    input  logic               wr_eop,
    input  logic               err_clr,
    output logic               wr_full,
    output logic [N_FLAGS-1:0] err_flags,
    output logic               err_pulse,
    output logic               ovf_flag,
    input  logic               rd_clk,
    input  logic               rd_rst,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic [PORT_W-1:0]  rd_tag,
    output logic               rd_sop,
    output logic               rd_eop,
    output logic               rd_empty
);
    localparam int WORD_W = DATA_W + FRAME_W;

    frame_t             in_frm, fixed_frm, out_frm;
    logic               accept, ovf_evt;
    logic [WORD_W-1:0]  wword, rword;

    assign in_frm = '{tag: wr_tag, sop: wr_sop, eop: wr_eop};

    tf_framer #(.NUM_PORTS(NUM_PORTS)) u_framer (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .clr       (err_clr),
        .accept    (accept),
        .in_frm    (in_frm),
        .out_frm   (fixed_frm),
        .err_flags (err_flags),
        .err_pulse (err_pulse)
    );

    assign wword = {wr_data, fixed_frm};

    tf_dcfifo #(.W(WORD_W), .ADDR_W(ADDR_W), .DROP_ON_FULL(DROP_ON_FULL)) u_fifo (
        .wclk    (wr_clk),
        .wrst    (wr_rst),
        .wr_req  (wr_en),
        .wdata   (wword),
        .full    (wr_full),
        .accept  (accept),
        .ovf_evt (ovf_evt),
        .rclk    (rd_clk),
        .rrst    (rd_rst),
        .rd_en   (rd_en),
        .rdata   (rword),
        .empty   (rd_empty)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_rst) ovf_flag <= 1'b0;
        else        ovf_flag <= (err_clr ? 1'b0 : ovf_flag) | ovf_evt;
    end

    assign out_frm = rword[FRAME_W-1:0];
    assign rd_data = rword[WORD_W-1:FRAME_W];
    assign rd_tag  = out_frm.tag;
    assign rd_sop  = out_frm.sop;
    assign rd_eop  = out_frm.eop;

    assert_ovf_sticky_R8: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (ovf_flag && !err_clr) |=> ovf_flag);
endmodule

// File: tb/tagged_tx_fifo_tb.sv
`timescale 1ns/1ps
module tagged_tx_fifo_tb;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, err_clr = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [7:0]        wr_tag = '0;
    logic              wr_full, err_pulse, ovf_flag, rd_sop, rd_eop, rd_empty;
    logic [3:0]        err_flags;
    logic [DATA_W-1:0] rd_data;
    logic [7:0]        rd_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tagged_tx_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PORTS(4), .DROP_ON_FULL(1'b1)) u_dut (
        .wr_clk(clk), .wr_rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
        .wr_sop(wr_sop), .wr_eop(wr_eop), .err_clr(err_clr), .wr_full(wr_full),
        .err_flags(err_flags), .err_pulse(err_pulse), .ovf_flag(ovf_flag),
        .rd_clk(clk), .rd_rst(rst), .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag),
        .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_empty(rd_empty)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one write; returns at the falling edge after the write edge
    task automatic push(input logic [7:0] tag, input logic [DATA_W-1:0] d, input logic s, input logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_tag = tag; wr_data = d; wr_sop = s; wr_eop = e;
        @(negedge clk);
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [7:0] tag, input logic [DATA_W-1:0] d,
                             input logic s, input logic e);
        for (int i = 0; i < 6 && rd_empty; i++) @(negedge clk);
        check(req, "not empty", 32'(rd_empty), 32'd0);
        check(req, "data", 32'(rd_data), 32'(d));
        check(req, "tag",  32'(rd_tag),  32'(tag));
        check(req, "sop",  32'(rd_sop),  32'(s));
        check(req, "eop",  32'(rd_eop),  32'(e));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R7", "empty after reset", 32'(rd_empty), 32'd1);
        check("R7", "full after reset",  32'(wr_full),  32'd0);
        check("R7", "flags after reset", 32'(err_flags), 32'd0);
        check("R7", "ovf after reset",   32'(ovf_flag), 32'd0);
        // read on empty buffer must not disturb anything
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        check("R7", "empty after idle read", 32'(rd_empty), 32'd1);
    endtask

    task automatic t_order();
        push(8'd0, 16'h1111, 1'b1, 1'b0);
        push(8'hC8, 16'h2222, 1'b0, 1'b0);
        push(8'd0, 16'h3333, 1'b0, 1'b0);
        push(8'd0, 16'h4444, 1'b0, 1'b1);
        push(8'd1, 16'h5555, 1'b1, 1'b1);
        check("R6", "no flags on good packets", 32'(err_flags), 32'd0);
        pop_check("R1", 8'd0,  16'h1111, 1'b1, 1'b0);
        pop_check("R1", 8'hC8, 16'h2222, 1'b0, 1'b0);
        pop_check("R1", 8'd0,  16'h3333, 1'b0, 1'b0);
        pop_check("R1", 8'd0,  16'h4444, 1'b0, 1'b1);
        pop_check("R1", 8'd1,  16'h5555, 1'b1, 1'b1);
        // port 0 closed by EOP: a new SOP is legal
        push(8'd0, 16'h6666, 1'b1, 1'b1);
        check("R6", "sop after eop legal", 32'(err_flags), 32'd0);
        pop_check("R6", 8'd0, 16'h6666, 1'b1, 1'b1);
    endtask

    task automatic t_missing_sop();
        push(8'd2, 16'hA001, 1'b0, 1'b0);
        check("R2", "pulse", 32'(err_pulse), 32'd1);
        check("R2", "flags", 32'(err_flags), 32'b0001);
        push(8'd2, 16'hA002, 1'b0, 1'b1);
        check("R2", "pulse after close", 32'(err_pulse), 32'd0);
        pop_check("R2", 8'd2, 16'hA001, 1'b1, 1'b0);
        pop_check("R2", 8'd2, 16'hA002, 1'b0, 1'b1);
        clear_flags();
        check("R9", "flags cleared", 32'(err_flags), 32'd0);
    endtask

    task automatic t_spur_eop();
        push(8'd3, 16'hB001, 1'b0, 1'b1);
        check("R3", "pulse", 32'(err_pulse), 32'd1);
        check("R3", "flags", 32'(err_flags), 32'b1000);
        pop_check("R3", 8'd3, 16'hB001, 1'b1, 1'b1);
        clear_flags();
        check("R9", "flags cleared", 32'(err_flags), 32'd0);
    endtask

    task automatic t_spur_sop();
        push(8'd1, 16'hC001, 1'b1, 1'b0);
        check("R4", "no flag on open", 32'(err_flags), 32'd0);
        push(8'd1, 16'hC002, 1'b1, 1'b0);
        check("R4", "pulse", 32'(err_pulse), 32'd1);
        check("R4", "flags", 32'(err_flags), 32'b0110);
        push(8'd1, 16'hC003, 1'b0, 1'b1);
        pop_check("R4", 8'd1, 16'hC001, 1'b1, 1'b0);
        pop_check("R4", 8'd1, 16'hC002, 1'b1, 1'b0);
        pop_check("R4", 8'd1, 16'hC003, 1'b0, 1'b1);
        // clear in the same cycle as a new error: new error still sets (R9)
        @(negedge clk);
        err_clr = 1'b1; wr_en = 1'b1; wr_tag = 8'd2; wr_data = 16'hC004; wr_sop = 1'b0; wr_eop = 1'b1;
        @(negedge clk);
        err_clr = 1'b0; wr_en = 1'b0; wr_eop = 1'b0;
        check("R9", "clear with new error", 32'(err_flags), 32'b1000);
        pop_check("R9", 8'd2, 16'hC004, 1'b1, 1'b1);
        clear_flags();
    endtask

    task automatic t_unchecked();
        push(8'd4, 16'hD001, 1'b0, 1'b1);
        push(8'hFF, 16'hD002, 1'b1, 1'b0);
        push(8'hFF, 16'hD003, 1'b1, 1'b0);
        push(8'hA5, 16'hD004, 1'b0, 1'b0);
        check("R5", "no flags", 32'(err_flags), 32'd0);
        check("R5", "no pulse", 32'(err_pulse), 32'd0);
        pop_check("R5", 8'd4,  16'hD001, 1'b0, 1'b1);
        pop_check("R5", 8'hFF, 16'hD002, 1'b1, 1'b0);
        pop_check("R5", 8'hFF, 16'hD003, 1'b1, 1'b0);
        pop_check("R5", 8'hA5, 16'hD004, 1'b0, 1'b0);
    endtask

    task automatic t_empty_latency();
        push(8'hC8, 16'hE001, 1'b0, 1'b0);
        check("R7", "empty 0.5 cycle after write", 32'(rd_empty), 32'd1);
        @(negedge clk);
        check("R7", "empty 1.5 cycles after write", 32'(rd_empty), 32'd1);
        @(negedge clk);
        check("R7", "not empty 2.5 cycles after write", 32'(rd_empty), 32'd0);
        pop_check("R7", 8'hC8, 16'hE001, 1'b0, 1'b0);
        check("R7", "empty after pop", 32'(rd_empty), 32'd1);
    endtask

    task automatic t_overflow();
        repeat (4) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            check("R10", "not full before last", 32'(wr_full), 32'd0);
            push(8'hC8, DATA_W'(16'hF000 + i), 1'b0, 1'b0);
        end
        check("R10", "full after depth writes", 32'(wr_full), 32'd1);
        check("R8", "no ovf yet", 32'(ovf_flag), 32'd0);
        push(8'hC8, 16'hDEAD, 1'b0, 1'b0);
        check("R8", "ovf set", 32'(ovf_flag), 32'd1);
        for (int i = 0; i < DEPTH; i++) pop_check("R8", 8'hC8, DATA_W'(16'hF000 + i), 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check("R8", "empty after drain", 32'(rd_empty), 32'd1);
        check("R8", "ovf sticky", 32'(ovf_flag), 32'd1);
        clear_flags();
        check("R9", "ovf cleared", 32'(ovf_flag), 32'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_missing_sop();
        t_spur_eop();
        t_spur_sop();
        t_unchecked();
        t_empty_latency();
        t_overflow();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule